// File: doc/BRIEF.md
# Overlay Memory Address Decoder

The block turns a 14-bit core address into one access per request. The access goes to internal memory, to an external overlay segment, or it raises an error. There are two address spaces, program and data. Each space has its own overlay selector. A selector of 0 keeps the switchable 8K window on internal memory. A selector of 1 or 2 sends that window to external segment 1 or 2.

The switchable window is not the same in the two spaces. In program space it is the upper half of the address range. In data space it is the lower half. For an external access, the external address takes its low 13 bits from the core address. Bit 13 comes from the overlay number, not from the address.

A boot-disable mode input forces the program selector to 0. In that mode the program space becomes one plain external 8K bank. External data accesses are held open for a programmable number of wait states. Ready marks the end of every access.

Top module: `ovl_addr_dec`

## Requirements
- R1: After reset, all three configuration registers read 0, and ext_strobe, int_sel, mmr_sel, acc_err and acc_rdy are all 0.
- R2: With boot_off=0 and the program selector at 0, program addresses below 0x2000 select internal memory. Program addresses from 0x2000 to 0x3FFF raise acc_err.
- R3: With the program selector at 1 or 2, program addresses from 0x2000 to 0x3FFF go external. ext_addr[12:0] equals acc_addr[12:0], and ext_addr[13] is 1 only for selector 2. ext_addr stays stable while the strobe is held.
- R4: With the data selector at 1 or 2, data addresses below 0x2000 go external, with the same address rule as R3. With the data selector at 0 they are internal. Data addresses from 0x2000 up are always internal.
- R5: A data access to 0x3FE0–0x3FFF is internal and also raises mmr_sel. No other access raises mmr_sel.
- R6: A window access whose selector is 3 raises acc_err and gives no ext_strobe. No error access ever strobes.
- R7: While boot_off=1, the program selector reads 0 and writes to it are ignored. Program addresses below 0x2000 go external with ext_addr = acc_addr. Program addresses from 0x2000 up raise acc_err.
- R8: acc_rdy is 1 one cycle after the accepting edge for internal, error and program-external accesses. For data-external accesses it is 1 after 1+W cycles, where W is the data wait register. The external strobe stays high through the ready cycle.
- R9: acc_rdy lasts exactly one cycle. A request that arrives while an access is in progress is ignored.
- R10: Configuration register codes on cfg_addr: 0 is the program selector (2 bits), 1 is the data selector (2 bits), 2 is the data wait (3 bits), and 3 reads 0. cfg_rdata returns the addressed register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_off | input | 1 | Boot-disable mode; forces the program selector to 0 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register code |
| cfg_wdata | input | 3 | Configuration write data |
| cfg_rdata | output | 3 | Configuration read data (combinational) |
| acc_req | input | 1 | Access request, taken when idle |
| acc_space | input | 1 | 0 = program space, 1 = data space |
| acc_addr | input | 14 | Core address |
| ext_addr | output | 14 | External address, 0 unless strobing |
| ext_strobe | output | 1 | External access in progress |
| int_sel | output | 1 | Internal access in progress |
| mmr_sel | output | 1 | Access hits the memory-mapped register area |
| acc_err | output | 1 | Illegal access |
| acc_rdy | output | 1 | Access completes this cycle |

## Verification
All access results are registered at the accepting edge. The select, error and address outputs are therefore due in the first cycle after the request. The bench samples them at the first falling edge after that rising edge. Ready is due after one cycle, or after 1+W cycles for data-external accesses. The bench counts falling edges from acceptance until ready and compares the count with that figure. It then checks one cycle later that the strobe and ready have both dropped. Configuration readback is combinational and is checked in the same cycle as the address change.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;

    localparam int unsigned AW      = 14;
    localparam int unsigned SEG_AW  = AW - 1;
    localparam int unsigned OVL_W   = 2;
    localparam int unsigned WAIT_W  = 3;
    localparam int unsigned CFG_DW  = (OVL_W > WAIT_W) ? OVL_W : WAIT_W;
    localparam int unsigned CFG_AW  = 2;
    localparam int unsigned MMR_N   = 32;
    localparam logic [AW-1:0] MMR_BASE = AW'((1 << AW) - MMR_N);

    typedef enum logic [CFG_AW-1:0] {
        CFG_PROG = 2'd0,
        CFG_DATA = 2'd1,
        CFG_WAIT = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic          err;
        logic          ext;
        logic          intl;
        logic          mmr;
        logic [AW-1:0] xaddr;
    } dec_t;

    function automatic logic ovl_valid(input logic [OVL_W-1:0] v);
        return (v == OVL_W'(1)) || (v == OVL_W'(2));
    endfunction

    function automatic logic [AW-1:0] ext_map(input logic seg, input logic [AW-1:0] a);
        return {seg, a[SEG_AW-1:0]};
    endfunction

endpackage

// File: rtl/ovl_cfg_regs.sv
`timescale 1ns/1ps
module ovl_cfg_regs
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_off,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output logic [CFG_DW-1:0] rdata,
    output logic [OVL_W-1:0]  prog_ovl,
    output logic [OVL_W-1:0]  data_ovl,
    output logic [WAIT_W-1:0] dwait
);

    logic [OVL_W-1:0]  prog_q;
    logic [OVL_W-1:0]  data_q;
    logic [WAIT_W-1:0] wait_q;
    cfg_sel_e          sel;

    assign sel = cfg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= '0;
            data_q <= '0;
            wait_q <= '0;
        end else begin
            if (boot_off)
                prog_q <= '0;
            else if (we && sel == CFG_PROG)
                prog_q <= wdata[OVL_W-1:0];
            if (we && sel == CFG_DATA)
                data_q <= wdata[OVL_W-1:0];
            if (we && sel == CFG_WAIT)
                wait_q <= wdata[WAIT_W-1:0];
        end
    end

    assign prog_ovl = boot_off ? '0 : prog_q;
    assign data_ovl = data_q;
    assign dwait    = wait_q;

    always_comb begin
        unique case (sel)
            CFG_PROG: rdata = CFG_DW'(prog_ovl);
            CFG_DATA: rdata = CFG_DW'(data_q);
            CFG_WAIT: rdata = CFG_DW'(wait_q);
            default:  rdata = '0;
        endcase
    end

    // R7: boot-disable mode leaves the stored program selector cleared
    p_boot_clears_r7: assert property (@(posedge clk) disable iff (rst)
        boot_off |=> (prog_q == '0));

endmodule

// File: rtl/ovl_space_dec.sv
`timescale 1ns/1ps
module ovl_space_dec
    import ovl_pkg::*;
#(
    parameter bit IS_DATA = 1'b0
)(
    input  logic             boot_off,
    input  logic [OVL_W-1:0] ovl,
    input  logic [AW-1:0]    addr,
    output dec_t             d
);

    logic boot_eff;
    logic hi;

    assign boot_eff = IS_DATA ? 1'b0 : boot_off;
    assign hi       = addr[AW-1];

    generate
        if (IS_DATA) begin : g_data
            always_comb begin
                d = '0;
                if (hi) begin
                    d.intl = 1'b1;
                    d.mmr  = (addr >= MMR_BASE);
                end else if (ovl == '0) begin
                    d.intl = 1'b1;
                end else if (ovl_valid(ovl)) begin
                    d.ext   = 1'b1;
                    d.xaddr = ext_map(ovl == OVL_W'(2), addr);
                end else begin
                    d.err = 1'b1 | boot_eff;
                end
            end
        end else begin : g_prog
            always_comb begin
                d = '0;
                if (boot_eff) begin
                    if (hi) begin
                        d.err = 1'b1;
                    end else begin
                        d.ext   = 1'b1;
                        d.xaddr = ext_map(1'b0, addr);
                    end
                end else if (!hi) begin
                    d.intl = 1'b1;
                end else if (ovl_valid(ovl)) begin
                    d.ext   = 1'b1;
                    d.xaddr = ext_map(ovl == OVL_W'(2), addr);
                end else begin
                    d.err = 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ovl_wait_seq.sv
`timescale 1ns/1ps
module ovl_wait_seq
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WAIT_W-1:0] load,
    output logic              busy,
    output logic              rdy
);

    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= load;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            busy <= 1'b0;
        end
    end

    assign rdy = busy && (cnt == '0);

    // R8: each wait state consumes exactly one cycle
    p_wait_step_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

    // R9: ready is a single-cycle pulse
    p_rdy_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);

endmodule

// File: rtl/ovl_addr_dec.sv
`timescale 1ns/1ps
module ovl_addr_dec
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_off,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              acc_req,
    input  logic              acc_space,
    input  logic [AW-1:0]     acc_addr,
    output logic [AW-1:0]     ext_addr,
    output logic              ext_strobe,
    output logic              int_sel,
    output logic              mmr_sel,
    output logic              acc_err,
    output logic              acc_rdy
);

    logic [OVL_W-1:0]  prog_ovl;
    logic [OVL_W-1:0]  data_ovl;
    logic [WAIT_W-1:0] dwait;
    dec_t              dec_p;
    dec_t              dec_d;
    dec_t              dec_sel;
    dec_t              dec_q;
    logic              busy;
    logic              rdy;
    logic              accept;
    logic [WAIT_W-1:0] wait_load;

    ovl_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .boot_off (boot_off),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .prog_ovl (prog_ovl),
        .data_ovl (data_ovl),
        .dwait    (dwait)
    );

    ovl_space_dec #(.IS_DATA(1'b0)) u_dec_prog (
        .boot_off (boot_off),
        .ovl      (prog_ovl),
        .addr     (acc_addr),
        .d        (dec_p)
    );

    ovl_space_dec #(.IS_DATA(1'b1)) u_dec_data (
        .boot_off (boot_off),
        .ovl      (data_ovl),
        .addr     (acc_addr),
        .d        (dec_d)
    );

    assign dec_sel   = acc_space ? dec_d : dec_p;
    assign accept    = acc_req && !busy;
    assign wait_load = (acc_space && dec_sel.ext) ? dwait : '0;

    always_ff @(posedge clk) begin
        if (rst)
            dec_q <= '0;
        else if (accept)
            dec_q <= dec_sel;
    end

    ovl_wait_seq u_wait (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .load  (wait_load),
        .busy  (busy),
        .rdy   (rdy)
    );

    assign ext_strobe = busy && dec_q.ext;
    assign int_sel    = busy && dec_q.intl;
    assign mmr_sel    = busy && dec_q.mmr;
    assign acc_err    = busy && dec_q.err;
    assign ext_addr   = ext_strobe ? dec_q.xaddr : '0;
    assign acc_rdy    = rdy;

    // R6: an illegal access never drives the external strobe
    p_err_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> !ext_strobe);

    // R3: the external address holds while the strobe stays open
    p_ext_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ext_strobe && !acc_rdy) |=> (ext_strobe && $stable(ext_addr)));

    // R8: internal and error accesses finish in their first cycle
    p_fast_done_r8: assert property (@(posedge clk) disable iff (rst)
        (int_sel || acc_err) |-> acc_rdy);

    // R5: the register area is only flagged on internal accesses
    p_mmr_internal_r5: assert property (@(posedge clk) disable iff (rst)
        mmr_sel |-> int_sel);

endmodule

// File: tb/test_ovl_addr_dec.sv
`timescale 1ns/1ps
module test_ovl_addr_dec;

    logic        clk = 1'b0;
    logic        rst;
    logic        boot_off;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [2:0]  cfg_wdata;
    logic [2:0]  cfg_rdata;
    logic        acc_req;
    logic        acc_space;
    logic [13:0] acc_addr;
    logic [13:0] ext_addr;
    logic        ext_strobe;
    logic        int_sel;
    logic        mmr_sel;
    logic        acc_err;
    logic        acc_rdy;

    int checks = 0;
    int errors = 0;
    int cur_pov = 0;
    int cur_dov = 0;
    int cur_wait = 0;

    always #5 clk = ~clk;

    ovl_addr_dec i_ovl_addr_dec (
        .clk(clk), .rst(rst), .boot_off(boot_off),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_req(acc_req), .acc_space(acc_space), .acc_addr(acc_addr),
        .ext_addr(ext_addr), .ext_strobe(ext_strobe), .int_sel(int_sel),
        .mmr_sel(mmr_sel), .acc_err(acc_err), .acc_rdy(acc_rdy)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 3'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input int a, input int exp, input string tag);
        cfg_addr = 2'(a);
        #1;
        chk(int'(cfg_rdata) == exp, tag, "cfg_rdata", int'(cfg_rdata), exp);
    endtask

    task automatic run_acc(input logic sp, input logic [13:0] a, input string tag);
        logic e_err, e_ext, e_int, e_mmr;
        logic [13:0] e_xa;
        int e_lat;
        int n;
        e_err = 0; e_ext = 0; e_int = 0; e_mmr = 0; e_xa = '0;
        if (!sp) begin
            if (boot_off) begin
                if (a >= 14'h2000) e_err = 1;
                else begin e_ext = 1; e_xa = a; end
            end else if (a < 14'h2000) e_int = 1;
            else if (cur_pov == 1) begin e_ext = 1; e_xa = a - 14'h2000; end
            else if (cur_pov == 2) begin e_ext = 1; e_xa = a; end
            else e_err = 1;
        end else begin
            if (a >= 14'h2000) begin e_int = 1; e_mmr = (a >= 14'h3FE0); end
            else if (cur_dov == 0) e_int = 1;
            else if (cur_dov == 1) begin e_ext = 1; e_xa = a; end
            else if (cur_dov == 2) begin e_ext = 1; e_xa = a + 14'h2000; end
            else e_err = 1;
        end
        e_lat = (sp && e_ext) ? 1 + cur_wait : 1;

        @(negedge clk);
        acc_req = 1'b1; acc_space = sp; acc_addr = a;
        @(negedge clk);
        acc_req = 1'b0;
        chk({ext_strobe, int_sel, acc_err, mmr_sel} == {e_ext, e_int, e_err, e_mmr}, tag, "select",
            int'({ext_strobe, int_sel, acc_err, mmr_sel}), int'({e_ext, e_int, e_err, e_mmr}));
        chk(ext_addr == e_xa, tag, "ext_addr", int'(ext_addr), int'(e_xa));
        n = 1;
        while (!acc_rdy && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == e_lat, "R8", "ready latency", n, e_lat);
        chk(ext_strobe == e_ext, "R8", "strobe at ready", int'(ext_strobe), int'(e_ext));
        @(negedge clk);
        chk(!acc_rdy && !ext_strobe && !int_sel, "R9", "idle after ready",
            int'({acc_rdy, ext_strobe, int_sel}), 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] addrs [9];
        addrs = '{14'h0000, 14'h0ABC, 14'h1FFF, 14'h2000, 14'h2A5A, 14'h3000, 14'h3FDF, 14'h3FE0, 14'h3FFF};
        rst = 1'b1; boot_off = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        acc_req = 1'b0; acc_space = 1'b0; acc_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int r = 0; r < 3; r++) cfg_check(r, 0, "R1");
        chk({ext_strobe, int_sel, mmr_sel, acc_err, acc_rdy} == 5'b0, "R1", "outputs idle",
            int'({ext_strobe, int_sel, mmr_sel, acc_err, acc_rdy}), 0);

        // R10: register codes and readback
        cfg_write(0, 2); cfg_write(1, 3); cfg_write(2, 5); cfg_write(3, 7);
        cfg_check(0, 2, "R10"); cfg_check(1, 3, "R10"); cfg_check(2, 5, "R10"); cfg_check(3, 0, "R10");
        cfg_write(0, 7);
        cfg_check(0, 3, "R10");

        // R2, R3, R6: program space sweep
        for (int ov = 0; ov < 4; ov++) begin
            cfg_write(0, ov); cur_pov = ov;
            cfg_check(0, ov, "R10");
            foreach (addrs[i])
                run_acc(1'b0, addrs[i], (ov == 0) ? "R2" : (ov == 3) ? "R6" : "R3");
        end

        // R4, R5, R6, R8: data space sweep over wait values
        for (int w = 0; w < 8; w++) begin
            cfg_write(2, w); cur_wait = w;
            for (int ov = 0; ov < 4; ov++) begin
                cfg_write(1, ov); cur_dov = ov;
                foreach (addrs[i])
                    run_acc(1'b1, addrs[i], (addrs[i] >= 14'h3FE0) ? "R5" : (ov == 3) ? "R6" : "R4");
            end
        end

        // R7: boot-disable mode
        cfg_write(0, 2); cur_pov = 2;
        @(negedge clk); boot_off = 1'b1;
        cfg_check(0, 0, "R7");
        cfg_write(0, 1);
        cfg_check(0, 0, "R7");
        foreach (addrs[i]) run_acc(1'b0, addrs[i], "R7");
        @(negedge clk); boot_off = 1'b0;
        cfg_check(0, 0, "R7");
        cur_pov = 0;
        run_acc(1'b0, 14'h2345, "R7");

        // R9: request during a busy access is ignored
        cfg_write(1, 1); cur_dov = 1;
        cfg_write(2, 3); cur_wait = 3;
        @(negedge clk);
        acc_req = 1'b1; acc_space = 1'b1; acc_addr = 14'h0123;
        @(negedge clk);
        acc_addr = 14'h0456; acc_space = 1'b0;
        begin
            int n;
            n = 1;
            chk(ext_addr == 14'h0123, "R9", "first addr", int'(ext_addr), 14'h0123);
            @(negedge clk);
            acc_req = 1'b0;
            n++;
            while (!acc_rdy && n < 20) begin
                chk(ext_addr == 14'h0123, "R9", "addr held", int'(ext_addr), 14'h0123);
                @(negedge clk);
                n++;
            end
            chk(n == 4, "R9", "ready latency under extra request", n, 4);
            @(negedge clk);
            chk(!ext_strobe && !int_sel && !acc_err, "R9", "no second access",
                int'({ext_strobe, int_sel, acc_err}), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule